// File: doc/BRIEF.md
# Rotate Unit with Extend

A purely combinational rotator for the execution stage of a 16/32-bit processor datapath. It turns an operand left or right by a count of up to 63 positions at one of three sizes: byte (8 bits), word (16 bits) or long (32 bits). A second mode lengthens the ring by one bit and places the extend flag above the operand's most significant bit. The extend flag then travels round the ring with the data, which gives ring lengths of 9, 17 and 33.

The unit returns the rotated result, zero-extended to 32 bits, together with a new extend bit and a carry bit. The rest of the condition-code logic uses those two bits. The unit is combinational, so its outputs follow its inputs within the same cycle, and the surrounding pipeline register captures them.

Top module: `rot_unit`

## Requirements
- R1: With thru_x_i=0 and dir_i=0, the low N bits of the operand rotate left by the count. N is 8, 16 or 32 for size_i codes 0, 1 and 2, and code 3 behaves like code 2.
- R2: With thru_x_i=0 and dir_i=1, the low N bits of the operand rotate right by the count.
- R3: With thru_x_i=1, the ring is {ext_i, operand[N-1:0]} of N+1 bits. It rotates in the direction given by dir_i (0 left, 1 right). The result holds the ring's low N bits.
- R4: The count is reduced modulo the ring length before rotating. A count equal to the ring length returns the operand unchanged (for example 32 for a plain long rotate, 33 for an extend long rotate, 9 for an extend byte rotate). A count of 63 equals 63 mod N in plain mode and 63 mod (N+1) in extend mode.
- R5: A count of zero returns the low N bits of the operand unchanged, in both modes.
- R6: In extend mode, x_o and c_o both equal the bit that ends up at the ring's top position. For a count of zero that bit is ext_i.
- R7: In plain mode, x_o equals ext_i. c_o is 0 when cnt_i is 0. Otherwise c_o is the last bit carried across the ring seam: result bit 0 for a left rotate, or result bit N-1 for a right rotate.
- R8: Result bits N and above are zero. Operand bits N and above have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to rotate |
| ext_i | input | 1 | Incoming extend flag |
| size_i | input | 2 | Size code: 0 byte, 1 word, 2 or 3 long |
| dir_i | input | 1 | 0 rotates left, 1 rotates right |
| thru_x_i | input | 1 | 1 includes the extend flag in the ring |
| cnt_i | input | 6 | Rotate count, 0 to 63 |
| result_o | output | 32 | Rotated value, zero-extended above the size |
| x_o | output | 1 | New extend flag |
| c_o | output | 1 | Carry flag |

## Verification
The bench targets counts that land exactly on a ring length (8, 9, 16, 17, 32, 33) and the largest count, 63. A unit that skipped the modulo step, or that wrapped a 32-position shift instead of clearing it, would return a corrupted long value where the operand itself is expected. It drives zero counts in both modes: a plain zero count must give carry 0, and an extend zero count must copy ext_i to both flags, so a unit that took the carry from the result would show a wrong flag. It also sets operand bits above the chosen size and uses size code 3, and a unit that leaked high bits or decoded code 3 as another size would show them in the result. A reference model rotates one position at a time, once per count, so every other case is checked against stepwise rotation rather than against shift arithmetic.

// File: rtl/rot_pkg.sv
package rot_pkg;
  // Size codes seen on the size select input.
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } rot_size_e;

  // Width of the plain ring for lane g, given the narrowest lane width.
  function automatic int lane_width(input int base_w, input int g);
    return base_w << g;
  endfunction
endpackage

// File: rtl/rot_ring.sv
// Rotates a ring of W bits by (cnt mod W), built from two opposite shifts.
// A shift amount equal to W produces zero, so a zero count adds nothing.
module rot_ring #(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     ring_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_i,
  output logic [W-1:0]     ring_o
);
  localparam int KW = $clog2(W + 1);

  logic [KW-1:0] k;
  logic [KW-1:0] back;
  logic [W-1:0]  near_part;
  logic [W-1:0]  far_part;

  always_comb begin
    k    = KW'(32'(cnt_i) % W);
    back = KW'(W) - k;
    if (dir_i) begin
      near_part = ring_i >> k;
      far_part  = ring_i << back;
    end else begin
      near_part = ring_i << k;
      far_part  = ring_i >> back;
    end
    ring_o = near_part | far_part;
  end
endmodule

// File: rtl/rot_lane.sv
// One operand size: a plain ring of PW bits and an extend ring of PW+1 bits.
module rot_lane #(
  parameter int PW    = 8,
  parameter int CNT_W = 6
) (
  input  logic [PW-1:0]    opnd_i,
  input  logic             ext_i,
  input  logic             dir_i,
  input  logic             thru_x_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [PW-1:0]    res_o,
  output logic             x_o,
  output logic             c_o
);
  logic [PW-1:0] plain_rot;
  logic [PW:0]   ext_rot;
  logic          cnt_zero;

  rot_ring #(.W(PW), .CNT_W(CNT_W)) u_plain (
    .ring_i (opnd_i),
    .cnt_i  (cnt_i),
    .dir_i  (dir_i),
    .ring_o (plain_rot)
  );

  rot_ring #(.W(PW + 1), .CNT_W(CNT_W)) u_ext (
    .ring_i ({ext_i, opnd_i}),
    .cnt_i  (cnt_i),
    .dir_i  (dir_i),
    .ring_o (ext_rot)
  );

  always_comb begin
    cnt_zero = (cnt_i == '0);
    if (thru_x_i) begin
      res_o = ext_rot[PW-1:0];
      x_o   = ext_rot[PW];
      c_o   = ext_rot[PW];
    end else begin
      res_o = plain_rot;
      x_o   = ext_i;
      if (cnt_zero)   c_o = 1'b0;
      else if (dir_i) c_o = plain_rot[PW-1];
      else            c_o = plain_rot[0];
    end
  end
endmodule

// File: rtl/rot_unit.sv
module rot_unit #(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  parameter int CNT_W     = 6,
  parameter int SEL_W     = 2,
  parameter int MAX_W     = BASE_W << (NUM_SIZES - 1)
) (
  input  logic [MAX_W-1:0] opnd_i,
  input  logic             ext_i,
  input  logic [SEL_W-1:0] size_i,
  input  logic             dir_i,
  input  logic             thru_x_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [MAX_W-1:0] result_o,
  output logic             x_o,
  output logic             c_o
);
  import rot_pkg::*;

  logic [MAX_W-1:0]     lane_res [NUM_SIZES];
  logic [NUM_SIZES-1:0] lane_x;
  logic [NUM_SIZES-1:0] lane_c;
  logic [SEL_W-1:0]     sel;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int PW = lane_width(BASE_W, g);
    logic [PW-1:0] res_g;

    rot_lane #(.PW(PW), .CNT_W(CNT_W)) u_lane (
      .opnd_i   (opnd_i[PW-1:0]),
      .ext_i    (ext_i),
      .dir_i    (dir_i),
      .thru_x_i (thru_x_i),
      .cnt_i    (cnt_i),
      .res_o    (res_g),
      .x_o      (lane_x[g]),
      .c_o      (lane_c[g])
    );

    assign lane_res[g] = MAX_W'(res_g);
  end

  // Codes beyond the widest lane fall back to the widest lane.
  always_comb begin
    if (int'(size_i) >= NUM_SIZES) sel = SEL_W'(NUM_SIZES - 1);
    else                           sel = size_i;
    result_o = lane_res[sel];
    x_o      = lane_x[sel];
    c_o      = lane_c[sel];
  end
endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk #(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  parameter int CNT_W     = 6,
  parameter int SEL_W     = 2,
  parameter int MAX_W     = BASE_W << (NUM_SIZES - 1)
) (
  input logic [MAX_W-1:0] opnd_i,
  input logic             ext_i,
  input logic [SEL_W-1:0] size_i,
  input logic             dir_i,
  input logic             thru_x_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [MAX_W-1:0] result_o,
  input logic             x_o,
  input logic             c_o
);
  int               pw;
  logic [MAX_W-1:0] mask;
  logic [MAX_W-1:0] opnd_m;

  always_comb begin
    if (int'(size_i) >= NUM_SIZES) pw = BASE_W << (NUM_SIZES - 1);
    else                           pw = BASE_W << int'(size_i);
    mask   = MAX_W'((64'd1 << pw) - 64'd1);
    opnd_m = opnd_i & mask;

    AST_UPPER_ZERO: assert ((result_o & ~mask) == '0); // R8
    AST_ZERO_CNT_SAME: assert (!(cnt_i == '0) || (result_o == opnd_m)); // R5
    AST_EXT_FLAGS_EQ: assert (!thru_x_i || (x_o == c_o)); // R6
    AST_EXT_ZERO_CNT: assert (!(thru_x_i && cnt_i == '0) || (c_o == ext_i)); // R6
    AST_PLAIN_X_KEEP: assert (thru_x_i || (x_o == ext_i)); // R7
    AST_PLAIN_ZERO_C: assert (!(!thru_x_i && cnt_i == '0) || !c_o); // R7
    AST_PLAIN_SEAM_C: assert (!(!thru_x_i && cnt_i != '0) ||
                              (c_o == (dir_i ? result_o[pw-1] : result_o[0]))); // R7
    AST_PLAIN_POP: assert (thru_x_i || ($countones(result_o) == $countones(opnd_m))); // R1
    AST_EXT_POP: assert (!thru_x_i ||
                         ($countones({x_o, result_o}) == $countones({ext_i, opnd_m}))); // R3
  end
endmodule

bind rot_unit rot_unit_chk #(
  .BASE_W    (BASE_W),
  .NUM_SIZES (NUM_SIZES),
  .CNT_W     (CNT_W),
  .SEL_W     (SEL_W),
  .MAX_W     (MAX_W)
) u_chk (.*);

// File: tb/rot_unit_tb.sv
`timescale 1ns/1ps
module rot_unit_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] opnd;
  logic        ext;
  logic [1:0]  size;
  logic        dir;
  logic        thru_x;
  logic [5:0]  cnt;
  logic [31:0] result;
  logic        x_out;
  logic        c_out;

  int checks;
  int failures;
  bit driving_done;
  bit finished;

  typedef struct {
    logic [31:0] res;
    logic        x;
    logic        c;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  rot_unit u_dut (
    .opnd_i   (opnd),
    .ext_i    (ext),
    .size_i   (size),
    .dir_i    (dir),
    .thru_x_i (thru_x),
    .cnt_i    (cnt),
    .result_o (result),
    .x_o      (x_out),
    .c_o      (c_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Stepwise reference: one single-position move per count step.
  function automatic exp_t model(input logic [31:0] op, input logic e, input logic [1:0] sz,
                                 input logic d, input logic tx, input logic [5:0] c,
                                 input string tag);
    exp_t        r;
    int          pw;
    int          len;
    logic [32:0] v;
    pw  = 8 << ((sz == 2'd3) ? 2 : int'(sz));
    len = pw + (tx ? 1 : 0);
    v   = '0;
    for (int i = 0; i < pw; i++) v[i] = op[i];
    if (tx) v[pw] = e;
    for (int s = 0; s < int'(c); s++) begin
      logic [32:0] n;
      n = '0;
      if (!d) begin
        n[0] = v[len-1];
        for (int j = 1; j < len; j++) n[j] = v[j-1];
      end else begin
        n[len-1] = v[0];
        for (int j = 0; j < len - 1; j++) n[j] = v[j+1];
      end
      v = n;
    end
    r.res = '0;
    for (int i = 0; i < pw; i++) r.res[i] = v[i];
    if (tx) begin
      r.x = v[pw];
      r.c = v[pw];
    end else begin
      r.x = e;
      r.c = (c == 6'd0) ? 1'b0 : (d ? r.res[pw-1] : r.res[0]);
    end
    r.tag = tag;
    return r;
  endfunction

  task automatic drive(input logic [31:0] op, input logic e, input logic [1:0] sz,
                       input logic d, input logic tx, input logic [5:0] c, input string tag);
    @(posedge clk);
    opnd   = op;
    ext    = e;
    size   = sz;
    dir    = d;
    thru_x = tx;
    cnt    = c;
    exp_q.push_back(model(op, e, sz, d, tx, c, tag));
  endtask

  // Monitor: compare on the falling edge, half a period after each drive.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (result !== it.res || x_out !== it.x || c_out !== it.c) begin
          failures++;
          $display("FAIL %s: res=%h x=%b c=%b expected res=%h x=%b c=%b",
                   it.tag, result, x_out, c_out, it.res, it.x, it.c);
        end
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        finished = 1'b1;
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst_n  = 1'b0;
    opnd   = '0;
    ext    = 1'b0;
    size   = 2'd0;
    dir    = 1'b0;
    thru_x = 1'b0;
    cnt    = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset-state inputs: all zero in, all zero out (R5).
    drive(32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 6'd0, "R5 reset state");
    // R1 plain left at each size
    drive(32'h0000_0081, 1'b0, 2'd0, 1'b0, 1'b0, 6'd1, "R1 byte left 1");
    drive(32'h0000_8001, 1'b0, 2'd1, 1'b0, 1'b0, 6'd4, "R1 word left 4");
    drive(32'h8000_0001, 1'b1, 2'd2, 1'b0, 1'b0, 6'd31, "R1 long left 31");
    drive(32'h1234_5678, 1'b0, 2'd3, 1'b0, 1'b0, 6'd8, "R1 size code 3");
    // R2 plain right
    drive(32'h0000_0001, 1'b0, 2'd0, 1'b1, 1'b0, 6'd1, "R2 byte right 1");
    drive(32'hDEAD_BEEF, 1'b0, 2'd2, 1'b1, 1'b0, 6'd12, "R2 long right 12");
    // R3 extend ring, both directions
    drive(32'h0000_0080, 1'b0, 2'd0, 1'b0, 1'b1, 6'd1, "R3 byte ext left 1");
    drive(32'h0000_0001, 1'b1, 2'd1, 1'b1, 1'b1, 6'd1, "R3 word ext right 1");
    drive(32'hF000_000F, 1'b1, 2'd2, 1'b0, 1'b1, 6'd5, "R3 long ext left 5");
    // R4 counts on ring lengths and the maximum count
    drive(32'hCAFE_F00D, 1'b0, 2'd2, 1'b0, 1'b0, 6'd32, "R4 long plain 32");
    drive(32'hCAFE_F00D, 1'b1, 2'd2, 1'b1, 1'b1, 6'd33, "R4 long ext 33");
    drive(32'h0000_00A5, 1'b1, 2'd0, 1'b0, 1'b1, 6'd9, "R4 byte ext 9");
    drive(32'h0000_00A5, 1'b0, 2'd0, 1'b0, 1'b0, 6'd63, "R4 byte plain 63");
    drive(32'h0000_5A3C, 1'b1, 2'd1, 1'b1, 1'b1, 6'd63, "R4 word ext 63");
    drive(32'h0000_5A3C, 1'b0, 2'd1, 1'b0, 1'b1, 6'd17, "R4 word ext 17");
    // R5 / R6 / R7 zero counts
    drive(32'h8765_4321, 1'b1, 2'd2, 1'b0, 1'b0, 6'd0, "R7 plain zero count carry");
    drive(32'h8765_4321, 1'b1, 2'd2, 1'b1, 1'b1, 6'd0, "R6 ext zero count flags");
    drive(32'h0000_00FF, 1'b0, 2'd0, 1'b0, 1'b1, 6'd0, "R5 ext zero count");
    // R8 high operand bits ignored
    drive(32'hFFFF_FF00, 1'b0, 2'd0, 1'b0, 1'b0, 6'd3, "R8 byte high bits");
    drive(32'hFFFF_0000, 1'b1, 2'd1, 1'b1, 1'b1, 6'd7, "R8 word high bits");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] op;
      logic [5:0]  c;
      op = $urandom;
      c  = 6'($urandom % 64);
      drive(op, 1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2),
            1'($urandom % 2), c, "R1 R2 R3 R6 R7 random");
    end

    driving_done = 1'b1;
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule